// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block sits between the command scheduler of a memory controller and the command bus of a four-bank SDRAM. The scheduler offers one command per cycle: an activate (bank plus row), a read or write (bank plus column), a precharge (bank) or an idle cycle. The guard answers in the same cycle whether that command may legally go out now. When it may, the command is forwarded in the same cycle and the per-bank bookkeeping is updated at the next clock edge. When it may not, the scheduler keeps the request in place until the guard accepts it.

The guard tracks three things for each bank: whether a row is open, which row it is, and the time since the bank's last activate. It also tracks one shared timer for the spacing between activates to any two banks. The minimum intervals are given in picoseconds together with the clock period. At elaboration each interval becomes a cycle count by ceiling division. With the defaults (5000 ps clock, 67/19/15 ns limits) this gives 14 cycles for same-bank activate spacing, 4 cycles for activate-to-access delay and 3 cycles for cross-bank activate spacing. A precharge closes its bank in the cycle it issues. The precharge recovery time is not checked.

Top module: `act_timing_guard`

## Requirements
- R1: After reset every bank is closed and every timer is clear. An activate to any bank is ready at once, and a read or write to any bank is not ready.
- R2: A request with operation code 0 (idle) is always ready. Codes 5 to 7 are treated as idle, are always ready and are forwarded as code 0.
- R3: A read (code 2) or write (code 3) to a bank with no open row is not ready.
- R4: A read or write to an open bank becomes ready only when at least ceil(T_RCD_PS/CLK_PS) cycles have passed since that bank's activate. With the defaults this is 4 cycles: not ready 1 to 3 cycles after, ready 4 cycles after.
- R5: An activate (code 1) to a bank whose row is still open is not ready, however much time has passed. Once a precharge (code 4) has closed the bank, the activate is ready again.
- R6: Two activates to the same bank are separated by at least ceil(T_RC_PS/CLK_PS) cycles. With the defaults this is 14 cycles, even when the bank was precharged in between.
- R7: Two activates to different banks are separated by at least ceil(T_RRD_PS/CLK_PS) cycles. With the defaults this is 3 cycles. An activate to another bank while one bank is open is allowed.
- R8: cmd_valid is high exactly when req_valid and req_ready are both high. The forwarded bank equals the request's bank. cmd_addr carries the row for an activate and the zero-extended column for a read or write. cmd_row carries the bank's open row for a read or write.
- R9: A precharge is always ready, even to a closed bank. The bank is closed from the next cycle, so a read to it is then not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A command is offered |
| req_op | input | 3 | Operation code: 0 idle, 1 activate, 2 read, 3 write, 4 precharge |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Row for an activate |
| req_col | input | 10 | Column for a read or write |
| req_ready | output | 1 | The offered command may issue this cycle |
| cmd_valid | output | 1 | A command goes out on the bus this cycle |
| cmd_op | output | 3 | Forwarded operation code |
| cmd_bank | output | 2 | Forwarded bank |
| cmd_addr | output | 13 | Row (activate) or column (read/write) address |
| cmd_row | output | 13 | Row that the access targets |

## Verification
Each timer is probed with a request held cycle by cycle from one cycle after an activate up to the first cycle it is accepted. This locates the exact acceptance cycle, so a counter that is one cycle short or long, or a ceiling rounded down (3 instead of 4 for the access delay), shows up as a mismatch. Activates to the same bank and to a different bank are mixed so that the three timers can be told apart. Precharge sequences separate the open-row rule from the same-bank spacing rule. Accesses to closed banks, idle and unused codes, and precharges to closed banks cover the cases that must always or never pass.

// File: rtl/act_guard_pkg.sv
package act_guard_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4
    } op_e;

    // Integer ceiling division used to turn picosecond limits into cycles
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/bank_tracker.sv
module bank_tracker #(
    parameter int ROW_W   = 13,
    parameter int RC_CYC  = 14,
    parameter int RCD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_fire,
    input  logic             pre_fire,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic             rc_clear,
    output logic             rcd_clear,
    output logic [ROW_W-1:0] open_row
);
    localparam int RC_W  = $clog2(RC_CYC + 1);
    localparam int RCD_W = $clog2(RCD_CYC + 1);
    localparam logic [RC_W-1:0]  RC_LOAD  = RC_W'(RC_CYC - 1);
    localparam logic [RCD_W-1:0] RCD_LOAD = RCD_W'(RCD_CYC - 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [RC_W-1:0]  rc;
        logic [RCD_W-1:0] rcd;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.rc  != '0) st_d.rc  = st_q.rc  - 1'b1;
        if (st_q.rcd != '0) st_d.rcd = st_q.rcd - 1'b1;
        if (act_fire) begin
            st_d.open = 1'b1;
            st_d.row  = act_row;
            st_d.rc   = RC_LOAD;
            st_d.rcd  = RCD_LOAD;
        end else if (pre_fire) begin
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign is_open   = st_q.open;
    assign rc_clear  = (st_q.rc == '0);
    assign rcd_clear = (st_q.rcd == '0);
    assign open_row  = st_q.row;

    // R5: an activate is only let through to a closed bank
    p_act_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> !st_q.open);

    // R9: a precharge leaves the bank closed from the next cycle
    p_pre_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_fire && !act_fire) |=> !is_open);

    generate
        if (RC_CYC > 1) begin : g_rc_chk
            // R6: the same-bank spacing window is running after an activate
            p_rc_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
                act_fire |=> !rc_clear);
        end
        if (RCD_CYC > 1) begin : g_rcd_chk
            // R4: access is blocked right after an activate
            p_rcd_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
                act_fire |=> !rcd_clear);
        end
    endgenerate

endmodule

// File: rtl/rrd_timer.sv
module rrd_timer #(
    parameter int RRD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_fire,
    output logic rrd_clear
);
    localparam int CNT_W = $clog2(RRD_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(RRD_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } rrd_st_t;

    rrd_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (act_fire)            st_d.cnt = LOAD;
        else if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rrd_clear = (st_q.cnt == '0);

    // R7: activates never pass while the cross-bank window is running
    p_rrd_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act_fire |-> rrd_clear);

endmodule

// File: rtl/act_timing_guard.sv
module act_timing_guard
    import act_guard_pkg::*;
#(
    parameter int CLK_PS   = 5000,
    parameter int T_RC_PS  = 67000,
    parameter int T_RCD_PS = 19000,
    parameter int T_RRD_PS = 15000,
    parameter int BANKS    = 4,
    parameter int ROW_W    = 13,
    parameter int COL_W    = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_op,
    input  logic [$clog2(BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]         req_row,
    input  logic [COL_W-1:0]         req_col,
    output logic                     req_ready,
    output logic                     cmd_valid,
    output logic [2:0]               cmd_op,
    output logic [$clog2(BANKS)-1:0] cmd_bank,
    output logic [ROW_W-1:0]         cmd_addr,
    output logic [ROW_W-1:0]         cmd_row
);
    localparam int RC_CYC  = (ceil_div(T_RC_PS,  CLK_PS) < 1) ? 1 : ceil_div(T_RC_PS,  CLK_PS);
    localparam int RCD_CYC = (ceil_div(T_RCD_PS, CLK_PS) < 1) ? 1 : ceil_div(T_RCD_PS, CLK_PS);
    localparam int RRD_CYC = (ceil_div(T_RRD_PS, CLK_PS) < 1) ? 1 : ceil_div(T_RRD_PS, CLK_PS);

    logic [BANKS-1:0] open_v, rc_v, rcd_v, act_v, pre_v;
    logic [ROW_W-1:0] row_v [BANKS];
    logic             rrd_ok;
    op_e              op;
    logic             fire;

    always_comb begin
        case (req_op)
            3'd1:    op = OP_ACT;
            3'd2:    op = OP_RD;
            3'd3:    op = OP_WR;
            3'd4:    op = OP_PRE;
            default: op = OP_NOP;
        endcase
    end

    always_comb begin
        case (op)
            OP_ACT:        req_ready = !open_v[req_bank] && rc_v[req_bank] && rrd_ok;
            OP_RD, OP_WR:  req_ready = open_v[req_bank] && rcd_v[req_bank];
            default:       req_ready = 1'b1;
        endcase
    end

    assign fire      = req_valid && req_ready;
    assign cmd_valid = fire;
    assign cmd_op    = op;
    assign cmd_bank  = req_bank;
    assign cmd_addr  = (op == OP_ACT) ? req_row : ROW_W'(req_col);
    assign cmd_row   = (op == OP_ACT) ? req_row : row_v[req_bank];

    generate
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            assign act_v[b] = fire && (op == OP_ACT) && (req_bank == b);
            assign pre_v[b] = fire && (op == OP_PRE) && (req_bank == b);

            bank_tracker #(
                .ROW_W  (ROW_W),
                .RC_CYC (RC_CYC),
                .RCD_CYC(RCD_CYC)
            ) i_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .act_fire (act_v[b]),
                .pre_fire (pre_v[b]),
                .act_row  (req_row),
                .is_open  (open_v[b]),
                .rc_clear (rc_v[b]),
                .rcd_clear(rcd_v[b]),
                .open_row (row_v[b])
            );
        end
    endgenerate

    rrd_timer #(
        .RRD_CYC(RRD_CYC)
    ) i_rrd (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_fire (fire && (op == OP_ACT)),
        .rrd_clear(rrd_ok)
    );

    // R2: idle requests are never held back
    p_nop_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op == OP_NOP) |-> req_ready);

    // R3: accesses go out only to banks that hold an open row
    p_acc_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR)) |-> open_v[cmd_bank]);

    // R4: accesses go out only once the activate-to-access window has ended
    p_acc_rcd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR)) |-> rcd_v[cmd_bank]);

    // R8: nothing is forwarded without a request
    p_fwd_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> req_valid);

endmodule

// File: tb/test_act_timing_guard.sv
module test_act_timing_guard;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [1:0]  req_bank;
    logic [12:0] req_row;
    logic [9:0]  req_col;
    logic        req_ready, cmd_valid;
    logic [2:0]  cmd_op;
    logic [1:0]  cmd_bank;
    logic [12:0] cmd_addr, cmd_row;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam int RC  = 14;
    localparam int RCD = 4;
    localparam int RRD = 3;

    always #2.5 clk = ~clk;

    act_timing_guard i_act_timing_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ready(req_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_row(cmd_row)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a request after the falling edge and check readiness before the rising edge
    task automatic offer(input int op, input int bank, input int row, input int col,
                         input bit exp_rdy, input string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 3'(op);
        req_bank  = 2'(bank);
        req_row   = 13'(row);
        req_col   = 10'(col);
        #1;
        chk(req_ready == exp_rdy, req, int'(req_ready), int'(exp_rdy));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_op    = 3'd0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_op = 3'd0; req_bank = '0; req_row = '0; req_col = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        for (int b = 0; b < 4; b++) offer(2, b, 0, 0, 1'b0, "R1 read after reset");
        offer(1, 3, 5, 0, 1'b1, "R1 activate after reset");
        idle(1);
    endtask

    task automatic t_idle_codes();
        do_reset();
        offer(0, 1, 0, 0, 1'b1, "R2 idle code 0");
        chk(cmd_valid == 1'b1, "R2 idle forwarded", int'(cmd_valid), 1);
        for (int c = 5; c < 8; c++) begin
            offer(c, 2, 0, 0, 1'b1, "R2 unused code");
            chk(cmd_op == 3'd0, "R2 unused code forwarded as idle", int'(cmd_op), 0);
        end
        idle(1);
    endtask

    task automatic t_closed_access();
        do_reset();
        offer(1, 0, 9, 0, 1'b1, "R3 activate bank0");
        idle(10);
        offer(3, 1, 0, 7, 1'b0, "R3 write to closed bank1");
        chk(cmd_valid == 1'b0, "R8 held request not forwarded", int'(cmd_valid), 0);
        offer(3, 0, 0, 7, 1'b1, "R3 write to open bank0");
        idle(1);
    endtask

    task automatic t_rcd_window();
        do_reset();
        offer(1, 0, 13'h1abc, 0, 1'b1, "R4 activate");
        chk(cmd_addr == 13'h1abc, "R8 activate row forwarded", int'(cmd_addr), 'h1abc);
        for (int k = 1; k < RCD; k++) offer(2, 0, 0, 10'h155, 1'b0, "R4 read too early");
        offer(2, 0, 0, 10'h155, 1'b1, "R4 read at tRCD");
        chk(cmd_valid && cmd_op == 3'd2 && cmd_bank == 2'd0, "R8 read forwarded",
            int'(cmd_valid), 1);
        chk(cmd_addr == 13'h155, "R8 column forwarded", int'(cmd_addr), 'h155);
        chk(cmd_row == 13'h1abc, "R8 open row forwarded", int'(cmd_row), 'h1abc);
        idle(1);
    endtask

    task automatic t_open_reject();
        do_reset();
        offer(1, 2, 33, 0, 1'b1, "R5 activate bank2");
        idle(20);
        offer(1, 2, 44, 0, 1'b0, "R5 activate to open bank");
        offer(4, 2, 0, 0, 1'b1, "R5 precharge bank2");
        offer(1, 2, 44, 0, 1'b1, "R5 activate after precharge");
        idle(1);
    endtask

    task automatic t_rc_window();
        do_reset();
        offer(1, 1, 1, 0, 1'b1, "R6 first activate");
        offer(4, 1, 0, 0, 1'b1, "R6 precharge");
        for (int k = 2; k < RC; k++) offer(1, 1, 2, 0, 1'b0, "R6 activate inside tRC");
        offer(1, 1, 2, 0, 1'b1, "R6 activate at tRC");
        idle(1);
    endtask

    task automatic t_rrd_window();
        do_reset();
        offer(1, 2, 3, 0, 1'b1, "R7 activate bank2");
        for (int k = 1; k < RRD; k++) offer(1, 3, 4, 0, 1'b0, "R7 other bank inside tRRD");
        offer(1, 3, 4, 0, 1'b1, "R7 other bank at tRRD");
        offer(1, 0, 5, 0, 1'b0, "R7 third bank right after");
        idle(1);
    endtask

    task automatic t_precharge();
        do_reset();
        offer(4, 3, 0, 0, 1'b1, "R9 precharge closed bank");
        offer(1, 0, 6, 0, 1'b1, "R9 activate bank0");
        idle(6);
        offer(4, 0, 0, 0, 1'b1, "R9 precharge bank0");
        offer(2, 0, 0, 1, 1'b0, "R9 read after precharge");
        idle(1);
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0;
        req_op = '0; req_bank = '0; req_row = '0; req_col = '0;
        t_reset_state();
        t_idle_codes();
        t_closed_access();
        t_rcd_window();
        t_open_reject();
        t_rc_window();
        t_rrd_window();
        t_precharge();
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule